// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This unit turns one 16-bit index extension word, plus any displacement words behind it, into a final 32-bit operand address. A pulse on `start` captures a base address (or a PC-relative selection) and the address at which the extension word sits. The unit then pulls the extension word and each displacement word from the instruction stream through a request/valid fetch port. It reads the selected index register through a combinational register-file read port. When the format asks for an indirect step, it issues one 32-bit read through a request/valid memory port.

Two extension formats are supported. The short form adds base, scaled index and an 8-bit signed offset. The long form allows an optional 16- or 32-bit base displacement, suppression of the base and of the index, and an optional memory-indirect step with the index applied either before or after the load, followed by an optional 16- or 32-bit outer displacement. When the unit finishes, it pulses `done` for one cycle. In that cycle it also presents the address, the updated instruction-stream address and a format-violation flag. Two parameters enable word-sized indexing and the long form. An extension word that needs a disabled feature ends the calculation at once.

Top module: `idxEaCalc`

## Requirements
- R1: With extension bit 8 = 0 (short form), the result is base + scaled index + the sign-extended extension bits 7:0. In PC-relative mode the base is the extension word's own address.
- R2: Extension bit 15 selects the index register class (1 = address, 0 = data) and bits 14:12 select its number, both presented on `regIsAddr`/`regNum`. Bit 11 = 0 sign-extends the low 16 bits of the register and bit 11 = 1 uses all 32 bits. Bits 10:9 shift the index left by 0 to 3.
- R3: If bit 11 = 0 while WORD_INDEX_EN = 0, or bit 8 = 1 while FULL_EXT_EN = 0, the unit asserts `illegal` with `done`, performs no fetch after the extension word and no memory read, and reports `nextPc` = extension address + 2.
- R4: In the long form, bits 5:4 set the base displacement: codes 0 and 1 mean none, code 2 means one sign-extended word, and code 3 means two words with the high word first.
- R5: In the long form, bit 7 = 1 replaces the base with zero. In PC-relative mode with bit 7 = 0, the base is the extension word address, and the base displacement is added to it.
- R6: In the long form with bits 1:0 = 0, the result is base + base displacement + index. The index is included only when bits 6 and 2 are both 0. No memory read occurs.
- R7: With bits 1:0 nonzero and bits 6 and 2 both 0 (pre-index), the memory read address is base + base displacement + index. The result is the loaded value + outer displacement.
- R8: With bits 1:0 nonzero and bit 6 = 0, bit 2 = 1 (post-index), the memory read address is base + base displacement. The result is loaded value + index + outer displacement. With bit 6 = 1 the index is left out in both places.
- R9: Bits 1:0 set the outer displacement: code 1 means none, code 2 means one sign-extended word, and code 3 means two words with the high word first. The outer displacement words are fetched after the base displacement words.
- R10: Fetches go to consecutive even addresses starting at the extension address, one fetch for each word consumed. `nextPc` equals the extension address + 2 × (1 + displacement words).
- R11: `done` lasts exactly one cycle per calculation. A `start` received while the unit is busy, including in the `done` cycle, is ignored.
- R12: A fetch or memory request stays asserted with a stable address until its valid arrives. The two requests are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| pcRel | input | 1 | Use the extension word address as the base |
| baseAddr | input | 32 | Base register value |
| extAddr | input | 32 | Address of the extension word |
| fetchReq | output | 1 | Instruction-stream word request |
| fetchAddr | output | 32 | Address of the requested word |
| fetchValid | input | 1 | Fetched word is present |
| fetchData | input | 16 | Fetched word |
| regIsAddr | output | 1 | Index register class (1 = address) |
| regNum | output | 3 | Index register number |
| regRdData | input | 32 | Index register value |
| memReq | output | 1 | Indirect operand read request |
| memAddr | output | 32 | Indirect read address |
| memValid | input | 1 | Read data is present |
| memData | input | 32 | Read data |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Format not permitted (valid with done) |
| eaOut | output | 32 | Computed effective address |
| nextPc | output | 32 | Instruction-stream address after the consumed words |

## Verification
The case of interest is a fresh `start` that arrives in the same cycle as the `done` strobe of the previous calculation. The bench raises `start` exactly in the observed `done` cycle after every calculation. It then judges that no fetch request follows and that `done` does not reappear. A second `start` with altered base inputs is also injected early in every busy window, and the result must still match the model computed from the first capture. Random stalls on both valid inputs exercise request holding and ordering.

// File: rtl/idxEaPkg.sv
package idxEaPkg;

  typedef enum logic [3:0] {
    S_IDLE, S_EXT, S_DEC, S_BD, S_CALC, S_MEM, S_OD, S_FIN, S_DONE
  } eaState_t;

  typedef struct packed {
    logic capture;
    logic loadExt;
    logic pcInc;
    logic clrDisp;
    logic shiftDisp;
    logic dispWide;
    logic calcInter;
    logic loadMem;
    logic calcFinal;
  } eaStrobe_t;

  // Size code to word count: 0,1 -> 0 words, 2 -> 1 word, 3 -> 2 words
  function automatic logic [1:0] dispWords(input logic [1:0] code);
    case (code)
      2'd2:    dispWords = 2'd1;
      2'd3:    dispWords = 2'd2;
      default: dispWords = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/idxEaIndex.sv
module idxEaIndex #(
  parameter int  ADDR_W        = 32,
  parameter int  WORD_W        = 16,
  parameter bit  WORD_INDEX_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] regData,
  input  logic              longSize,
  input  logic [1:0]        scale,
  output logic [ADDR_W-1:0] idxVal
);
  localparam int EXT_BITS = ADDR_W - WORD_W;

  logic [ADDR_W-1:0] sized;

  generate
    if (WORD_INDEX_EN) begin : g_wordIdx
      always_comb
        sized = longSize ? regData
                         : {{EXT_BITS{regData[WORD_W-1]}}, regData[WORD_W-1:0]};
    end else begin : g_longOnly
      logic unusedSize;
      assign unusedSize = longSize;
      always_comb sized = regData;
    end
  endgenerate

  assign idxVal = sized << scale;
endmodule

// File: rtl/idxEaDatapath.sv
module idxEaDatapath
  import idxEaPkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int WORD_W        = 16,
  parameter bit WORD_INDEX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobe_t         stb,
  input  logic              startPcRel,
  input  logic [ADDR_W-1:0] startBase,
  input  logic [ADDR_W-1:0] startExtAddr,
  input  logic [WORD_W-1:0] fetchData,
  input  logic [ADDR_W-1:0] memData,
  input  logic [ADDR_W-1:0] regRdData,
  output logic [WORD_W-1:0] ext,
  output logic [ADDR_W-1:0] pcAddr,
  output logic [ADDR_W-1:0] interAddr,
  output logic [ADDR_W-1:0] eaOut
);
  localparam int SHORT_W = 8;
  localparam int WORD_BYTES = WORD_W / 8;

  logic              pcRelQ;
  logic [ADDR_W-1:0] baseQ, extAddrQ, dispAcc, memBaseQ;
  logic [ADDR_W-1:0] idxVal, dispVal, effBase, shortOff;
  logic              preIdx, postIdx;

  idxEaIndex #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORD_INDEX_EN(WORD_INDEX_EN)
  ) uIndex (
    .regData (regRdData),
    .longSize(ext[11]),
    .scale   (ext[10:9]),
    .idxVal  (idxVal)
  );

  assign effBase  = pcRelQ ? extAddrQ : baseQ;
  assign shortOff = {{(ADDR_W-SHORT_W){ext[SHORT_W-1]}}, ext[SHORT_W-1:0]};
  assign dispVal  = stb.dispWide ? dispAcc
                  : {{(ADDR_W-WORD_W){dispAcc[WORD_W-1]}}, dispAcc[WORD_W-1:0]};
  assign preIdx   = !ext[6] && !ext[2];
  assign postIdx  = !ext[6] &&  ext[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcRelQ    <= 1'b0;
      baseQ     <= '0;
      extAddrQ  <= '0;
      pcAddr    <= '0;
      ext       <= '0;
      dispAcc   <= '0;
      interAddr <= '0;
      memBaseQ  <= '0;
      eaOut     <= '0;
    end else begin
      if (stb.capture) begin
        pcRelQ   <= startPcRel;
        baseQ    <= startBase;
        extAddrQ <= startExtAddr;
        pcAddr   <= startExtAddr;
      end
      if (stb.pcInc) pcAddr <= pcAddr + ADDR_W'(WORD_BYTES);
      if (stb.loadExt) ext <= fetchData;
      if (stb.clrDisp) dispAcc <= '0;
      else if (stb.shiftDisp) dispAcc <= {dispAcc[ADDR_W-WORD_W-1:0], fetchData};
      if (stb.calcInter)
        interAddr <= (ext[7] ? '0 : effBase) + dispVal + (preIdx ? idxVal : '0);
      if (stb.loadMem) memBaseQ <= memData;
      if (stb.calcFinal) begin
        if (!ext[8])             eaOut <= effBase + idxVal + shortOff;
        else if (ext[1:0] == 0)  eaOut <= interAddr;
        else                     eaOut <= memBaseQ + (postIdx ? idxVal : '0) + dispVal;
      end
    end
  end
endmodule

// File: rtl/idxEaControl.sv
module idxEaControl
  import idxEaPkg::*;
#(
  parameter int WORD_W        = 16,
  parameter bit WORD_INDEX_EN = 1'b1,
  parameter bit FULL_EXT_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] ext,
  input  logic              fetchValid,
  input  logic              memValid,
  output eaStrobe_t         stb,
  output logic              fetchReq,
  output logic              memReq,
  output logic              done,
  output logic              illegal
);
  eaState_t   state, nxt;
  logic [1:0] cnt;
  logic       illQ, badFmt;
  logic [1:0] bdWords, odWords;

  assign bdWords = dispWords(ext[5:4]);
  assign odWords = dispWords(ext[1:0]);
  assign badFmt  = (!ext[11] && !WORD_INDEX_EN) || (ext[8] && !FULL_EXT_EN);

  always_comb begin
    stb      = '0;
    nxt      = state;
    fetchReq = 1'b0;
    memReq   = 1'b0;
    done     = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        stb.capture = 1'b1;
        nxt = S_EXT;
      end
      S_EXT: begin
        fetchReq = 1'b1;
        if (fetchValid) begin
          stb.loadExt = 1'b1;
          stb.pcInc   = 1'b1;
          nxt = S_DEC;
        end
      end
      S_DEC: begin
        if (badFmt)       nxt = S_DONE;
        else if (!ext[8]) nxt = S_FIN;
        else begin
          stb.clrDisp = 1'b1;
          nxt = (bdWords != 0) ? S_BD : S_CALC;
        end
      end
      S_BD, S_OD: begin
        fetchReq = 1'b1;
        if (fetchValid) begin
          stb.shiftDisp = 1'b1;
          stb.pcInc     = 1'b1;
          if (cnt == 2'd1) nxt = (state == S_BD) ? S_CALC : S_FIN;
        end
      end
      S_CALC: begin
        stb.calcInter = 1'b1;
        stb.dispWide  = (bdWords == 2'd2);
        stb.clrDisp   = 1'b1;
        nxt = (ext[1:0] == 2'd0) ? S_FIN : S_MEM;
      end
      S_MEM: begin
        memReq = 1'b1;
        if (memValid) begin
          stb.loadMem = 1'b1;
          nxt = (odWords != 0) ? S_OD : S_FIN;
        end
      end
      S_FIN: begin
        stb.calcFinal = 1'b1;
        stb.dispWide  = (odWords == 2'd2);
        nxt = S_DONE;
      end
      S_DONE: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign illegal = done && illQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      illQ  <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.capture) illQ <= 1'b0;
      else if (state == S_DEC && badFmt) illQ <= 1'b1;
      if (state == S_DEC) cnt <= bdWords;
      else if (state == S_MEM && memValid) cnt <= odWords;
      else if (stb.shiftDisp) cnt <= cnt - 2'd1;
    end
  end
endmodule

// File: rtl/idxEaCalc.sv
module idxEaCalc
  import idxEaPkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int WORD_W        = 16,
  parameter bit WORD_INDEX_EN = 1'b1,
  parameter bit FULL_EXT_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              pcRel,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] extAddr,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchValid,
  input  logic [WORD_W-1:0] fetchData,
  output logic              regIsAddr,
  output logic [2:0]        regNum,
  input  logic [ADDR_W-1:0] regRdData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memData,
  output logic              done,
  output logic              illegal,
  output logic [ADDR_W-1:0] eaOut,
  output logic [ADDR_W-1:0] nextPc
);
  eaStrobe_t         stb;
  logic [WORD_W-1:0] ext;
  logic [ADDR_W-1:0] pcAddr;

  idxEaControl #(
    .WORD_W(WORD_W), .WORD_INDEX_EN(WORD_INDEX_EN), .FULL_EXT_EN(FULL_EXT_EN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .ext(ext),
    .fetchValid(fetchValid), .memValid(memValid), .stb(stb),
    .fetchReq(fetchReq), .memReq(memReq), .done(done), .illegal(illegal)
  );

  idxEaDatapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORD_INDEX_EN(WORD_INDEX_EN)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .startPcRel(pcRel),
    .startBase(baseAddr), .startExtAddr(extAddr), .fetchData(fetchData),
    .memData(memData), .regRdData(regRdData), .ext(ext), .pcAddr(pcAddr),
    .interAddr(memAddr), .eaOut(eaOut)
  );

  assign fetchAddr = pcAddr;
  assign nextPc    = pcAddr;
  assign regIsAddr = ext[15];
  assign regNum    = ext[14:12];
endmodule

// File: rtl/idxEaCalcChk.sv
module idxEaCalcChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchValid,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid,
  input logic              done,
  input logic              illegal
);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !fetchReq && !memReq);

  a_r3_illegal_with_done: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  a_r3_illegal_no_fetch_mem: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !fetchReq && !memReq);

  a_r12_fetch_hold: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchValid |=> fetchReq && $stable(fetchAddr));

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchReq && memReq));
endmodule

bind idxEaCalc idxEaCalcChk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
  .fetchValid(fetchValid), .memReq(memReq), .memAddr(memAddr),
  .memValid(memValid), .done(done), .illegal(illegal)
);

// File: tb/test_idxEaCalc.sv
module test_idxEaCalc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // main instance signals
  logic        start = 1'b0, pcRel = 1'b0;
  logic [31:0] baseAddr = '0, extAddr = '0;
  logic        fetchReq, fetchValid, regIsAddr, memReq, memValid, done, illegal;
  logic [31:0] fetchAddr, regRdData, memAddr, memData, eaOut, nextPc;
  logic [15:0] fetchData;
  logic [2:0]  regNum;
  logic        stallF = 1'b0, stallM = 1'b0;
  logic [15:0] codeArr [8];
  logic [31:0] regs [16];
  logic [31:0] curExt = '0;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC0DE_1357;
  endfunction

  assign fetchValid = fetchReq && !stallF;
  assign fetchData  = codeArr[3'((fetchAddr - curExt) >> 1)];
  assign regRdData  = regs[{regIsAddr, regNum}];
  assign memValid   = memReq && !stallM;
  assign memData    = memFn(memAddr);

  idxEaCalc i_idxEaCalc (
    .clk(clk), .rstN(rstN), .start(start), .pcRel(pcRel), .baseAddr(baseAddr),
    .extAddr(extAddr), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchData(fetchData), .regIsAddr(regIsAddr),
    .regNum(regNum), .regRdData(regRdData), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .done(done), .illegal(illegal),
    .eaOut(eaOut), .nextPc(nextPc)
  );

  // restricted instance: both feature parameters off
  logic        lStart = 1'b0;
  logic [31:0] lBase = '0, lExtAddr = '0;
  logic [15:0] lExt = '0;
  logic        lFetchReq, lRegIsAddr, lMemReq, lDone, lIllegal;
  logic [31:0] lFetchAddr, lMemAddr, lEa, lNextPc;
  logic [2:0]  lRegNum;

  idxEaCalc #(.WORD_INDEX_EN(1'b0), .FULL_EXT_EN(1'b0)) i_idxEaCalc_lim (
    .clk(clk), .rstN(rstN), .start(lStart), .pcRel(1'b0), .baseAddr(lBase),
    .extAddr(lExtAddr), .fetchReq(lFetchReq), .fetchAddr(lFetchAddr),
    .fetchValid(1'b1), .fetchData(lExt), .regIsAddr(lRegIsAddr),
    .regNum(lRegNum), .regRdData(32'd0), .memReq(lMemReq), .memAddr(lMemAddr),
    .memValid(1'b1), .memData(32'h1111_2222), .done(lDone), .illegal(lIllegal),
    .eaOut(lEa), .nextPc(lNextPc)
  );

  // handshake counters
  logic clrCnt = 1'b0;
  int fetchCnt = 0, memCnt = 0, lFetchCnt = 0, lMemCnt = 0;
  logic [31:0] seenMemAddr = '0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (clrCnt) begin
      fetchCnt <= 0; memCnt <= 0; lFetchCnt <= 0; lMemCnt <= 0;
    end else begin
      if (fetchReq && fetchValid) fetchCnt <= fetchCnt + 1;
      if (memReq && memValid) begin memCnt <= memCnt + 1; seenMemAddr <= memAddr; end
      if (lFetchReq) lFetchCnt <= lFetchCnt + 1;
      if (lMemReq) lMemCnt <= lMemCnt + 1;
    end
  end

  always @(negedge clk) begin
    stallF <= ($urandom % 4) == 0;
    stallM <= ($urandom % 3) == 0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] idxOf(input logic [15:0] e);
    logic [31:0] r;
    r = regs[{e[15], e[14:12]}];
    if (!e[11]) r = {{16{r[15]}}, r[15:0]};
    return r << e[10:9];
  endfunction

  function automatic int nWords(input logic [1:0] c);
    return (c == 2'd2) ? 1 : (c == 2'd3) ? 2 : 0;
  endfunction

  // model from the requirements
  task automatic model(input logic [15:0] e, input logic [31:0] base, input bit pr,
                       input logic [31:0] xa, output logic [31:0] ea,
                       output logic [31:0] npc, output logic [31:0] ma,
                       output int words, output bit ind);
    logic [31:0] idx, bd, od, b, inter, eb;
    int nb, no, p;
    idx = idxOf(e);
    eb = pr ? xa : base;
    ind = 1'b0; ma = '0;
    if (!e[8]) begin
      ea = eb + idx + {{24{e[7]}}, e[7:0]};
      words = 0;
    end else begin
      nb = nWords(e[5:4]); no = nWords(e[1:0]); p = 1;
      bd = 0;
      if (nb == 1) begin bd = {{16{codeArr[p][15]}}, codeArr[p]}; end
      if (nb == 2) begin bd = {codeArr[p], codeArr[p+1]}; end
      p += nb;
      od = 0;
      if (no == 1) od = {{16{codeArr[p][15]}}, codeArr[p]};
      if (no == 2) od = {codeArr[p], codeArr[p+1]};
      b = e[7] ? 32'd0 : eb;
      inter = b + bd + ((!e[6] && !e[2]) ? idx : 32'd0);
      if (e[1:0] == 0) ea = inter;
      else begin
        ind = 1'b1; ma = inter;
        ea = memFn(inter) + ((!e[6] && e[2]) ? idx : 32'd0) + od;
      end
      words = nb + no;
    end
    npc = xa + 32'(2 * (1 + words));
  endtask

  task automatic runOne(input logic [15:0] e, input logic [31:0] base, input bit pr,
                        input logic [31:0] xa, input string tag);
    logic [31:0] expEa, expPc, expMa;
    int words, wait_n;
    bit ind;
    codeArr[0] = e;
    curExt = xa;
    model(e, base, pr, xa, expEa, expPc, expMa, words, ind);
    @(negedge clk);
    start = 1'b1; baseAddr = base; pcRel = pr; extAddr = xa; clrCnt = 1'b1;
    @(negedge clk);
    clrCnt = 1'b0;
    baseAddr = $urandom; pcRel = ~pr; extAddr = $urandom; // R11 busy start
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 300) begin @(negedge clk); wait_n++; end
    check(done == 1'b1, {tag, " R11 done seen"}, 32'(done), 32'd1);
    check(eaOut == expEa, {tag, " ea"}, eaOut, expEa);
    check(nextPc == expPc, {tag, " R10 nextPc"}, nextPc, expPc);
    check(illegal == 1'b0, {tag, " R3 legal"}, 32'(illegal), 32'd0);
    check(fetchCnt == 1 + words, {tag, " R10 fetch count"}, 32'(fetchCnt), 32'(1 + words));
    check(memCnt == (ind ? 1 : 0), {tag, " R6 mem count"}, 32'(memCnt), 32'(ind ? 1 : 0));
    if (ind) check(seenMemAddr == expMa, {tag, " R7 R8 mem addr"}, seenMemAddr, expMa);
    start = 1'b1; // coincides with done: must be ignored
    @(negedge clk);
    start = 1'b0;
    check(!done && !fetchReq, {tag, " R11 start in done cycle"}, {30'd0, done, fetchReq}, 32'd0);
    @(negedge clk);
    check(!fetchReq && !memReq, {tag, " R11 stays idle"}, {30'd0, fetchReq, memReq}, 32'd0);
  endtask

  task automatic runLim(input logic [15:0] e, input logic [31:0] base, input logic [31:0] xa,
                        input bit expIll, input logic [31:0] expEa);
    int wait_n;
    @(negedge clk);
    lExt = e; lBase = base; lExtAddr = xa; lStart = 1'b1; clrCnt = 1'b1;
    @(negedge clk);
    lStart = 1'b0; clrCnt = 1'b0;
    wait_n = 0;
    while (!lDone && wait_n < 50) begin @(negedge clk); wait_n++; end
    check(lDone == 1'b1, "R3 lim done", 32'(lDone), 32'd1);
    check(lIllegal == expIll, "R3 illegal flag", 32'(lIllegal), 32'(expIll));
    check(lFetchCnt == 1, "R3 single fetch", 32'(lFetchCnt), 32'd1);
    check(lMemCnt == 0, "R3 no mem read", 32'(lMemCnt), 32'd0);
    check(lNextPc == xa + 32'd2, "R3 nextPc", lNextPc, xa + 32'd2);
    if (!expIll) check(lEa == expEa, "R1 lim ea", lEa, expEa);
  endtask

  task automatic fillRandom();
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    for (int i = 1; i < 8; i++) codeArr[i] = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) codeArr[i] = '0;
    for (int i = 0; i < 16; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    check(!done && !fetchReq && !memReq && !illegal, "R11 reset quiet",
          {28'd0, done, fetchReq, memReq, illegal}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: R1 R2 short form, PC-relative, word index negative, scale 4
    fillRandom();
    regs[3] = 32'h1234_FFF0;
    runOne(16'h3480, 32'h0, 1'b1, 32'h0000_1000, "R1 R2 short pcrel");
    // R2 address register, long size, scale 8
    regs[8 + 5] = 32'h0001_0000;
    runOne(16'hDE10, 32'h4000_0000, 1'b0, 32'h0000_2000, "R2 long idx");
    // R5 R6 base and index suppressed, 16-bit bd (value 0x8000 -> negative)
    codeArr[1] = 16'h8000;
    runOne(16'h09E0, 32'h5555_0000, 1'b0, 32'h0000_3000, "R4 R5 R6 bd only");
    // R4 R7 R9 32-bit bd, pre-index, 32-bit od
    codeArr[1] = 16'h0001; codeArr[2] = 16'h0200; codeArr[3] = 16'hFFFF; codeArr[4] = 16'hFFFE;
    runOne(16'h1933, 32'h0010_0000, 1'b0, 32'h0000_4000, "R7 R9 pre-index");
    // R8 post-index, 16-bit od
    codeArr[1] = 16'h0040; codeArr[2] = 16'h7FFF;
    runOne(16'h1926, 32'h0020_0000, 1'b0, 32'h0000_5000, "R8 post-index");
    // R5 PC-relative long form, no indirection
    codeArr[1] = 16'h0100;
    runOne(16'h0920, 32'hDEAD_0000, 1'b1, 32'h0000_6000, "R5 pcrel full");
    // R9 indirect with no od, index suppressed
    runOne(16'h0951, 32'h0030_0000, 1'b0, 32'h0000_7000, "R9 no od");

    // R3 restricted instance
    runLim(16'h0010, 32'h100, 32'h8000, 1'b1, 32'h0);
    runLim(16'h0900, 32'h100, 32'h8100, 1'b1, 32'h0);
    runLim(16'h0834, 32'h100, 32'h8200, 1'b0, 32'h134);
    runLim(16'h08F0, 32'h100, 32'h8300, 1'b0, 32'hF0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [15:0] e;
      fillRandom();
      e = 16'($urandom);
      if (($urandom % 3) == 0) e[8] = 1'b0;
      runOne(e, $urandom, 1'($urandom), {$urandom % 32'h0100_0000, 1'b0} & 32'hFFFF_FFF0,
             "R1 R4 R6 R7 R8 R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule